// File: doc/BRIEF.md
# Cache SRAM Write-Path Error Injector

This block sits on the write path between a cache controller and its tag and data SRAM arrays. It corrupts entries on purpose as they are written, so that the parity and ECC checkers downstream can be tested on real stored faults. The ECC byte and the tag parity bit arrive already computed. The block only decides whether to invert the parity bit, which data bits to invert, and what check byte to store.

Software programs the block through a small synchronous register bus. It sets an enable for tag corruption and an enable for data corruption. It also sets a 64-bit data inversion mask, held as a low and a high 32-bit word, and an 8-bit inversion mask for the check byte. A mirror option makes the array store the top byte of the write data in place of the computed ECC. Software then sets the stored check pattern exactly, through that byte and the ECC mask. The corruption logic is combinational and adds no cycle to either array path. Read data coming back from the data array passes through untouched.

Top module: `cache_wr_err_injector`

## Requirements
- R1: After reset the control word and both mask words are zero, and every write passes through with no change.
- R2: While the tag enable (control bit 16, counting bit 0 as least significant) is set, every tag write (tag_we high) stores the inverse of the incoming parity bit. The tag word itself is never altered.
- R3: While the data enable (control bit 9) is set, a data write inverts each of data bits 31..0 whose bit is set in the low mask word (register address 1).
- R4: While the data enable is set, a data write inverts each of data bits 63..32 whose bit is set in the high mask word (register address 2, bit n maps to data bit 32+n).
- R5: While the data enable is set, a data write inverts each stored ECC bit whose bit is set in the ECC mask (control bits 7..0).
- R6: While both the data enable and the mirror enable (control bit 10) are set, the stored check byte is write-data bits 63..56 taken before any data inversion, then XORed with the ECC mask. The incoming ECC is discarded.
- R7: While the data enable is clear, the masks and the mirror enable have no effect: data and ECC are stored exactly as presented.
- R8: The control register is at address 0. Only bits 16, 10, 9 and 7..0 hold state, and written values in all other bits are dropped and read back as zero. Reads return the addressed register one clock after the address is presented. Unmapped addresses read zero.
- R9: Data read from the array (word and ECC) reaches the controller unmodified in the same cycle.
- R10: When no write is strobed (tag_we or dat_we low), the corresponding outputs equal the inputs whatever the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | ADDR_W (4) | Register address |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, one cycle after address |
| tag_we | input | 1 | Tag array write strobe |
| tag_word_in | input | TAG_W (20) | Tag entry from controller |
| tag_par_in | input | 1 | Computed tag parity |
| tag_word_out | output | TAG_W (20) | Tag entry to array |
| tag_par_out | output | 1 | Parity bit to array |
| dat_we | input | 1 | Data array write strobe |
| dat_wdata_in | input | DATA_W (64) | Write data from controller |
| dat_ecc_in | input | 8 | Computed ECC byte |
| dat_wdata_out | output | DATA_W (64) | Write data to array |
| dat_ecc_out | output | 8 | ECC byte to array |
| rd_data_in | input | DATA_W (64) | Read data from array |
| rd_ecc_in | input | 8 | Read ECC from array |
| rd_data_out | output | DATA_W (64) | Read data to controller |
| rd_ecc_out | output | 8 | Read ECC to controller |

## Verification
The only state is the configuration, and a wrong bit in it shows at the ports in one of two ways. A register read shows it one clock after the address is presented. The next strobed write of the matching kind shows it as wrong inverted bits in the same cycle. A stuck enable shows up on the first write with a non-zero mask. A wrong mask bit shows up only once a write runs with the data enable set. So the checks pair every configuration change with a readback and with a strobed write. The writes use patterns whose top byte differs from the incoming ECC, so that a mirror fault cannot hide.

// File: rtl/errinj_pkg.sv
package errinj_pkg;

    localparam int REG_W   = 32;
    localparam int ECC_W   = 8;

    // Control word bit positions (bit 0 = least significant)
    localparam int CB_TAG_EN  = 16;
    localparam int CB_MIRROR  = 10;
    localparam int CB_DATA_EN = 9;
    localparam int CB_ECC_LO  = 0;

    localparam logic [REG_W-1:0] CTRL_LIVE = 32'h0001_06FF;

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_MASK = 1;   // first mask word; following words at +1

    typedef struct packed {
        logic             tag_en;
        logic             mirror_en;
        logic             data_en;
        logic [ECC_W-1:0] ecc_mask;
    } inj_ctrl_t;

endpackage

// File: rtl/errinj_regs.sv
module errinj_regs
    import errinj_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output inj_ctrl_t         ctrl,
    output logic [DATA_W-1:0] inv_mask
);

    localparam int NWORDS = DATA_W / REG_W;

    inj_ctrl_t         ctrl_q;
    logic [DATA_W-1:0] mask_q;
    logic [REG_W-1:0]  rd_mux;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (we && addr == ADDR_W'(ADDR_CTRL)) begin
            ctrl_q.tag_en    <= wdata[CB_TAG_EN];
            ctrl_q.mirror_en <= wdata[CB_MIRROR];
            ctrl_q.data_en   <= wdata[CB_DATA_EN];
            ctrl_q.ecc_mask  <= wdata[CB_ECC_LO +: ECC_W];
        end
    end

    for (genvar w = 0; w < NWORDS; w++) begin : g_mask
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[w*REG_W +: REG_W] <= '0;
            end else if (we && addr == ADDR_W'(ADDR_MASK + w)) begin
                mask_q[w*REG_W +: REG_W] <= wdata;
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        if (addr == ADDR_W'(ADDR_CTRL)) begin
            rd_mux[CB_TAG_EN]              = ctrl_q.tag_en;
            rd_mux[CB_MIRROR]              = ctrl_q.mirror_en;
            rd_mux[CB_DATA_EN]             = ctrl_q.data_en;
            rd_mux[CB_ECC_LO +: ECC_W]     = ctrl_q.ecc_mask;
        end
        for (int w = 0; w < NWORDS; w++) begin
            if (addr == ADDR_W'(ADDR_MASK + w)) begin
                rd_mux = mask_q[w*REG_W +: REG_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_mux;
    end

    assign ctrl     = ctrl_q;
    assign inv_mask = mask_q;

endmodule

// File: rtl/errinj_tag_path.sv
module errinj_tag_path
    import errinj_pkg::*;
#(
    parameter int TAG_W = 20
) (
    input  logic             we,
    input  inj_ctrl_t        ctrl,
    input  logic [TAG_W-1:0] word_in,
    input  logic             par_in,
    output logic [TAG_W-1:0] word_out,
    output logic             par_out
);

    assign word_out = word_in;
    assign par_out  = par_in ^ (we & ctrl.tag_en);

endmodule

// File: rtl/errinj_data_path.sv
module errinj_data_path
    import errinj_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              we,
    input  inj_ctrl_t         ctrl,
    input  logic [DATA_W-1:0] inv_mask,
    input  logic [DATA_W-1:0] data_in,
    input  logic [ECC_W-1:0]  ecc_in,
    output logic [DATA_W-1:0] data_out,
    output logic [ECC_W-1:0]  ecc_out
);

    logic             active;
    logic [ECC_W-1:0] check_base;

    assign active = we & ctrl.data_en;

    always_comb begin
        check_base = ctrl.mirror_en ? data_in[DATA_W-1 -: ECC_W] : ecc_in;
        if (active) begin
            data_out = data_in ^ inv_mask;
            ecc_out  = check_base ^ ctrl.ecc_mask;
        end else begin
            data_out = data_in;
            ecc_out  = ecc_in;
        end
    end

endmodule

// File: rtl/cache_wr_err_injector.sv
module cache_wr_err_injector
    import errinj_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int TAG_W  = 20,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              tag_we,
    input  logic [TAG_W-1:0]  tag_word_in,
    input  logic              tag_par_in,
    output logic [TAG_W-1:0]  tag_word_out,
    output logic              tag_par_out,
    input  logic              dat_we,
    input  logic [DATA_W-1:0] dat_wdata_in,
    input  logic [7:0]        dat_ecc_in,
    output logic [DATA_W-1:0] dat_wdata_out,
    output logic [7:0]        dat_ecc_out,
    input  logic [DATA_W-1:0] rd_data_in,
    input  logic [7:0]        rd_ecc_in,
    output logic [DATA_W-1:0] rd_data_out,
    output logic [7:0]        rd_ecc_out
);

    inj_ctrl_t         ctrl;
    logic [DATA_W-1:0] inv_mask;

    errinj_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (cfg_addr),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .ctrl     (ctrl),
        .inv_mask (inv_mask)
    );

    errinj_tag_path #(.TAG_W(TAG_W)) u_tag (
        .we       (tag_we),
        .ctrl     (ctrl),
        .word_in  (tag_word_in),
        .par_in   (tag_par_in),
        .word_out (tag_word_out),
        .par_out  (tag_par_out)
    );

    errinj_data_path #(.DATA_W(DATA_W)) u_data (
        .we       (dat_we),
        .ctrl     (ctrl),
        .inv_mask (inv_mask),
        .data_in  (dat_wdata_in),
        .ecc_in   (dat_ecc_in),
        .data_out (dat_wdata_out),
        .ecc_out  (dat_ecc_out)
    );

    assign rd_data_out = rd_data_in;
    assign rd_ecc_out  = rd_ecc_in;

endmodule

// File: rtl/errinj_checker.sv
module errinj_checker
    import errinj_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input inj_ctrl_t         ctrl,
    input logic [DATA_W-1:0] inv_mask,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [31:0]       cfg_rdata,
    input logic              tag_we,
    input logic              tag_par_in,
    input logic              tag_par_out,
    input logic              dat_we,
    input logic [DATA_W-1:0] dat_wdata_in,
    input logic [7:0]        dat_ecc_in,
    input logic [DATA_W-1:0] dat_wdata_out,
    input logic [7:0]        dat_ecc_out
);

    a_r1_cfg_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl == '0 && inv_mask == '0));

    a_r2_tag_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_we && ctrl.tag_en) |-> (tag_par_out != tag_par_in));

    a_r10_tag_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !tag_we |-> (tag_par_out == tag_par_in));

    a_r7_data_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.data_en |-> (dat_wdata_out == dat_wdata_in && dat_ecc_out == dat_ecc_in));

    a_r3_flip_count: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && ctrl.data_en) |->
            ($countones(dat_wdata_out ^ dat_wdata_in) == $countones(inv_mask)));

    a_r6_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && ctrl.data_en && ctrl.mirror_en) |->
            ((dat_ecc_out ^ ctrl.ecc_mask) == dat_wdata_in[DATA_W-1 -: 8]));

    a_r8_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == ADDR_W'(ADDR_CTRL)) |=> ((cfg_rdata & ~CTRL_LIVE) == '0));

endmodule

bind cache_wr_err_injector errinj_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl          (ctrl),
    .inv_mask      (inv_mask),
    .cfg_addr      (cfg_addr),
    .cfg_rdata     (cfg_rdata),
    .tag_we        (tag_we),
    .tag_par_in    (tag_par_in),
    .tag_par_out   (tag_par_out),
    .dat_we        (dat_we),
    .dat_wdata_in  (dat_wdata_in),
    .dat_ecc_in    (dat_ecc_in),
    .dat_wdata_out (dat_wdata_out),
    .dat_ecc_out   (dat_ecc_out)
);

// File: tb/cache_wr_err_injector_bench.sv
`timescale 1ns/1ps
module cache_wr_err_injector_bench;

    localparam int DW = 64;
    localparam int TW = 20;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic          cfg_we = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          tag_we = 1'b0;
    logic [TW-1:0] tag_word_in = '0;
    logic          tag_par_in = 1'b0;
    logic [TW-1:0] tag_word_out;
    logic          tag_par_out;
    logic          dat_we = 1'b0;
    logic [DW-1:0] dat_wdata_in = '0;
    logic [7:0]    dat_ecc_in = '0;
    logic [DW-1:0] dat_wdata_out;
    logic [7:0]    dat_ecc_out;
    logic [DW-1:0] rd_data_in = '0;
    logic [7:0]    rd_ecc_in = '0;
    logic [DW-1:0] rd_data_out;
    logic [7:0]    rd_ecc_out;

    always #2.5 clk = ~clk;

    cache_wr_err_injector #(.DATA_W(DW), .TAG_W(TW), .ADDR_W(AW)) u_cache_wr_err_injector (
        .clk(clk), .rst_n(rst_n),
        .cfg_addr(cfg_addr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .tag_we(tag_we), .tag_word_in(tag_word_in), .tag_par_in(tag_par_in),
        .tag_word_out(tag_word_out), .tag_par_out(tag_par_out),
        .dat_we(dat_we), .dat_wdata_in(dat_wdata_in), .dat_ecc_in(dat_ecc_in),
        .dat_wdata_out(dat_wdata_out), .dat_ecc_out(dat_ecc_out),
        .rd_data_in(rd_data_in), .rd_ecc_in(rd_ecc_in),
        .rd_data_out(rd_data_out), .rd_ecc_out(rd_ecc_out)
    );

    typedef struct {
        string         req;
        logic [TW-1:0] tword;
        logic          tpar;
        logic [DW-1:0] data;
        logic [7:0]    ecc;
        logic [DW-1:0] rdata;
        logic [7:0]    recc;
    } exp_t;

    exp_t sb_q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // Bench view of the programmed configuration, from the requirements
    logic          m_tag = 0, m_mir = 0, m_den = 0;
    logic [7:0]    m_eccm = '0;
    logic [DW-1:0] m_mask = '0;

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        cfg_addr = a; cfg_we = 1'b1; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        if (a == 0) begin
            m_tag = d[16]; m_mir = d[10]; m_den = d[9]; m_eccm = d[7:0];
        end else if (a == 1) m_mask[31:0] = d;
        else if (a == 2) m_mask[63:32] = d;
    endtask

    task automatic reg_read(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
        @(posedge clk); #1;
        cfg_addr = a;
        @(posedge clk);
        @(negedge clk);
        check(req, DW'(cfg_rdata), DW'(exp));
    endtask

    // Driver: applies one write-path pattern and queues what the ports must show
    task automatic drive(input string req, input logic twe, input logic [TW-1:0] tw,
                         input logic tp, input logic dwe, input logic [DW-1:0] d,
                         input logic [7:0] e, input logic [DW-1:0] rd, input logic [7:0] re);
        exp_t x;
        logic [7:0] base;
        @(posedge clk); #1;
        tag_we = twe; tag_word_in = tw; tag_par_in = tp;
        dat_we = dwe; dat_wdata_in = d; dat_ecc_in = e;
        rd_data_in = rd; rd_ecc_in = re;
        x.req = req; x.tword = tw; x.tpar = tp ^ (twe & m_tag);
        x.rdata = rd; x.recc = re;
        if (dwe && m_den) begin
            base   = m_mir ? d[63:56] : e;
            x.data = d ^ m_mask;
            x.ecc  = base ^ m_eccm;
        end else begin
            x.data = d;
            x.ecc  = e;
        end
        sb_q.push_back(x);
    endtask

    // Monitor: compares the ports half a cycle after each drive
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t x;
                x = sb_q.pop_front();
                check({x.req, " tag word"}, DW'(tag_word_out), DW'(x.tword));
                check({x.req, " tag parity"}, DW'(tag_par_out), DW'(x.tpar));
                check({x.req, " data"}, dat_wdata_out, x.data);
                check({x.req, " ecc"}, DW'(dat_ecc_out), DW'(x.ecc));
                check({x.req, " R9 read data"}, rd_data_out, x.rdata);
                check({x.req, " R9 read ecc"}, DW'(rd_ecc_out), DW'(x.recc));
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state and pass-through
        reg_read("R1 ctrl", 4'd0, 32'h0);
        reg_read("R1 mask lo", 4'd1, 32'h0);
        reg_read("R1 mask hi", 4'd2, 32'h0);
        drive("R1", 1, 20'hABCDE, 1, 1, 64'hDEAD_BEEF_0123_4567, 8'h3C, 64'h1111_2222_3333_4444, 8'h55);

        // R7: masks programmed but data enable clear
        reg_write(4'd1, 32'hFFFF_0000);
        reg_write(4'd2, 32'h0000_00FF);
        reg_write(4'd0, 32'h0000_04FF);
        drive("R7", 1, 20'h12345, 0, 1, 64'h0F0F_0F0F_F0F0_F0F0, 8'h81, 64'h0, 8'h0);

        // R2: tag enable inverts parity only on strobed tag writes
        reg_write(4'd0, 32'h0001_0000);
        reg_read("R2 ctrl", 4'd0, 32'h0001_0000);
        drive("R2", 1, 20'h00F0F, 0, 1, 64'hAAAA_5555_AAAA_5555, 8'h12, 64'h9, 8'h9);
        drive("R2", 1, 20'hFFFFF, 1, 0, 64'h0, 8'h0, 64'h0, 8'h0);
        drive("R10 tag idle", 0, 20'h55555, 1, 0, 64'h0, 8'h0, 64'h0, 8'h0);

        // R3: low mask word
        reg_write(4'd1, 32'hA5A5_0001);
        reg_write(4'd2, 32'h0);
        reg_write(4'd0, 32'h0000_0200);
        reg_read("R3 mask lo", 4'd1, 32'hA5A5_0001);
        drive("R3", 0, 20'h0, 0, 1, 64'h1234_5678_9ABC_DEF0, 8'h77, 64'h0, 8'h0);
        drive("R3", 0, 20'h0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 64'h0, 8'h0);

        // R4: high mask word
        reg_write(4'd1, 32'h0);
        reg_write(4'd2, 32'h8000_0F01);
        reg_read("R4 mask hi", 4'd2, 32'h8000_0F01);
        drive("R4", 0, 20'h0, 0, 1, 64'h0000_0000_FFFF_FFFF, 8'h44, 64'h0, 8'h0);

        // R5: ECC mask on computed ECC
        reg_write(4'd0, 32'h0000_02C3);
        drive("R5", 0, 20'h0, 0, 1, 64'h7700_0000_0000_0000, 8'h5A, 64'h0, 8'h0);

        // R6: mirror top data byte then apply ECC mask, with data mask live
        reg_write(4'd0, 32'h0000_060F);
        reg_write(4'd2, 32'hFF00_0000);
        drive("R6", 0, 20'h0, 0, 1, 64'h9300_0000_0000_0001, 8'hEE, 64'h0, 8'h0);
        reg_write(4'd0, 32'h0000_0600);
        drive("R6 zero mask", 0, 20'h0, 0, 1, 64'hC800_0000_0000_0000, 8'h11, 64'h0, 8'h0);

        // R10: no data strobe, full corruption configured
        reg_write(4'd0, 32'h0001_06FF);
        drive("R10 data idle", 0, 20'h0, 0, 0, 64'h0123_4567_89AB_CDEF, 8'h99, 64'hFEDC, 8'h01);

        // R9: read path under active corruption
        drive("R9", 1, 20'hC0FFE, 1, 1, 64'h5, 8'h6, 64'hCAFE_F00D_1234_5678, 8'hA7);

        // R8: reserved bits dropped, unmapped address reads zero
        reg_write(4'd0, 32'hFFFF_FFFF);
        reg_read("R8 ctrl rsvd", 4'd0, 32'h0001_06FF);
        reg_write(4'd0, 32'hFFFE_F900);
        reg_read("R8 ctrl rsvd only", 4'd0, 32'h0);
        reg_read("R8 unmapped", 4'd7, 32'h0);
        drive("R8 no effect", 1, 20'h1, 0, 1, 64'hFF00_0000_0000_00FF, 8'h3E, 64'h0, 8'h0);

        @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule